// File: doc/BRIEF.md
# DMA Completion and Drain Tracker

This block keeps count of how far each outstanding DMA transfer has progressed. It sits downstream of a request splitter, which breaks a transfer into chunks. A transfer is opened on one of several tag slots by giving its total byte count and an extra completion delay. Each chunk response names the slot it belongs to and the size that was requested for that chunk. The slot adds that requested size to its running sum, so a payload that was padded out to a full line does not credit extra bytes. When the sum reaches the total, the slot waits out its programmed delay. It then pulses that tag's bit of the completion vector and becomes free in the same cycle.

A separate counter follows the number of chunks in flight across all slots. The splitter pulses a queued strobe for each chunk it issues, and each response takes one off the count. A drain request is answered at once when nothing is in flight. Otherwise the block holds a draining status until the count falls back to zero, and then reports drain-done. Misuse is recorded in two sticky flags, which only reset clears. One flag is for a response that would overshoot a transfer or that hits a slot not collecting. The other is for a response that arrives when nothing is in flight.

Transfers are opened over a valid/ready handshake. Ready is low while the addressed tag is still busy, and the opener must hold its request until ready is high. Responses carry only a valid strobe, because the block has no storage to stall with: every response is consumed in the cycle it is presented. `NUM_SLOTS` must be a power of two of at least 2.

Top module: `dma_done_tracker`

## Requirements
- R1: After reset all slots are free, no flag, pulse or draining status is set, and `start_ready_o` is high. `start_ready_o` is high exactly when the slot named by `start_tag_i` is free. A start is taken when `start_valid_i` and `start_ready_o` are both high, and the slot's received sum starts at zero.
- R2: While a slot is collecting, each response to its tag adds `rsp_bytes_i` (the requested chunk size) to the received sum. The transfer completes when the sum equals the total given at start.
- R3: The response that makes the sum equal the total is presented in cycle c, and D is the delay given at start. Bit tag of `done_o` is then high for exactly one cycle, in cycle c+2+D.
- R4: A response that would lift the sum above the total sets `err_overflow_o`, and so does a response to a slot that is not collecting. Such a response leaves the sum unchanged, and the flag stays set until reset.
- R5: A start whose total is zero completes without any response. Its `done_o` bit pulses in cycle s+2+D, where s is the start cycle.
- R6: The in-flight count rises by one on a `chunk_queued_i` cycle without a response and falls by one on a response cycle without a queued strobe. When both arrive in the same cycle it is unchanged.
- R7: A response without a queued strobe in a cycle where the in-flight count is zero sets `err_underflow_o`, which stays set until reset. The count stays at zero.
- R8: `drain_req_i` while not draining and with a zero in-flight count gives a one-cycle `drain_done_o` pulse in the next cycle.
- R9: `drain_req_i` with a non-zero count raises `draining_o` from the next cycle on. The first cycle in which `draining_o` is high and the count is zero is followed by one `drain_done_o` cycle, and `draining_o` drops at the same time.
- R10: A slot is free in the cycle its `done_o` bit is high, so `start_ready_o` for that tag is high in that cycle.
- R11: Delays run on a separate counter in each slot, so several slots can wait at once, each completing on its own schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid_i | input | 1 | Request to open a transfer |
| start_ready_o | output | 1 | Addressed slot is free |
| start_tag_i | input | TAG_W | Slot to open |
| start_bytes_i | input | BYTE_W | Total bytes of the transfer |
| start_delay_i | input | DLY_W | Extra completion delay in cycles |
| chunk_queued_i | input | 1 | One chunk issued by the splitter |
| rsp_valid_i | input | 1 | Chunk response present |
| rsp_tag_i | input | TAG_W | Slot the response belongs to |
| rsp_bytes_i | input | BYTE_W | Requested size of that chunk |
| drain_req_i | input | 1 | Drain request strobe |
| done_o | output | NUM_SLOTS | Per-tag completion pulse |
| draining_o | output | 1 | Waiting for in-flight chunks to return |
| drain_done_o | output | 1 | Drain complete pulse |
| err_overflow_o | output | 1 | Sticky overshoot / stray response flag |
| err_underflow_o | output | 1 | Sticky response-with-nothing-in-flight flag |

## Verification
The bench builds the tracker with four slots, 12-bit byte counts, 4-bit delays and an 8-bit in-flight counter. With four slots, every tag can be open at the same moment. With 4-bit delays, the longest delay of 15 cycles is reached often during the random phase, so staggered completions with overlapping waits come up regularly. The small byte range makes it likely that random responses overshoot or land on a slot that is free or waiting. The two error flags are therefore also covered by directed cases after a fresh reset.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE    = 2'd0,
    SLOT_COLLECT = 2'd1,
    SLOT_HOLD    = 2'd2
  } slot_st_e;
endpackage

// File: rtl/dma_slot_ctl.sv
module dma_slot_ctl
  import dma_trk_pkg::*;
#(
  parameter int BYTE_W = 16,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] start_total_i,
  input  logic [DLY_W-1:0]  start_delay_i,
  input  logic              rsp_i,
  input  logic [BYTE_W-1:0] rsp_size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ovf_o
);
  slot_st_e          st_q;
  logic [BYTE_W-1:0] total_q;
  logic [BYTE_W-1:0] rcvd_q;
  logic [DLY_W-1:0]  dly_q;
  logic [DLY_W-1:0]  wait_q;
  logic              done_q;
  logic [BYTE_W:0]   sum;
  logic              over;

  assign sum    = {1'b0, rcvd_q} + {1'b0, rsp_size_i};
  assign over   = sum > {1'b0, total_q};
  assign busy_o = (st_q != SLOT_FREE);
  assign done_o = done_q;
  // a response is only legal while collecting and within the total
  assign ovf_o  = rsp_i && ((st_q != SLOT_COLLECT) || over);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SLOT_FREE;
      total_q <= '0;
      rcvd_q  <= '0;
      dly_q   <= '0;
      wait_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SLOT_FREE: begin
          if (start_i) begin
            total_q <= start_total_i;
            rcvd_q  <= '0;
            dly_q   <= start_delay_i;
            if (start_total_i == '0) begin
              st_q   <= SLOT_HOLD;
              wait_q <= start_delay_i;
            end else begin
              st_q <= SLOT_COLLECT;
            end
          end
        end
        SLOT_COLLECT: begin
          if (rsp_i && !over) begin
            rcvd_q <= sum[BYTE_W-1:0];
            if (sum == {1'b0, total_q}) begin
              st_q   <= SLOT_HOLD;
              wait_q <= dly_q;
            end
          end
        end
        SLOT_HOLD: begin
          if (wait_q == '0) begin
            done_q <= 1'b1;
            st_q   <= SLOT_FREE;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        default: st_q <= SLOT_FREE;
      endcase
    end
  end
endmodule

// File: rtl/dma_inflight_ctr.sv
module dma_inflight_ctr #(
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [OUT_W-1:0] cnt_o,
  output logic             unf_o
);
  logic [OUT_W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign unf_o = dec_i && !inc_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dma_drain_fsm.sv
module dma_drain_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic empty_i,
  output logic draining_o,
  output logic done_o
);
  logic draining_q;
  logic done_q;

  assign draining_o = draining_q;
  assign done_o     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      draining_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (draining_q) begin
        if (empty_i) begin
          draining_q <= 1'b0;
          done_q     <= 1'b1;
        end
      end else if (req_i) begin
        if (empty_i) done_q <= 1'b1;
        else         draining_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_done_tracker.sv
module dma_done_tracker #(
  parameter int NUM_SLOTS = 4,
  parameter int BYTE_W    = 16,
  parameter int DLY_W     = 8,
  parameter int OUT_W     = 10,
  localparam int TAG_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_valid_i,
  output logic                 start_ready_o,
  input  logic [TAG_W-1:0]     start_tag_i,
  input  logic [BYTE_W-1:0]    start_bytes_i,
  input  logic [DLY_W-1:0]     start_delay_i,
  input  logic                 chunk_queued_i,
  input  logic                 rsp_valid_i,
  input  logic [TAG_W-1:0]     rsp_tag_i,
  input  logic [BYTE_W-1:0]    rsp_bytes_i,
  input  logic                 drain_req_i,
  output logic [NUM_SLOTS-1:0] done_o,
  output logic                 draining_o,
  output logic                 drain_done_o,
  output logic                 err_overflow_o,
  output logic                 err_underflow_o
);
  logic [NUM_SLOTS-1:0] slot_busy;
  logic [NUM_SLOTS-1:0] slot_ovf;
  logic [OUT_W-1:0]     out_cnt;
  logic                 cnt_unf;
  logic                 start_take;
  logic                 ovf_q;
  logic                 unf_q;

  assign start_ready_o = !slot_busy[start_tag_i];
  assign start_take    = start_valid_i && start_ready_o;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    dma_slot_ctl #(
      .BYTE_W(BYTE_W),
      .DLY_W (DLY_W)
    ) slot_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_take && (start_tag_i == TAG_W'(g))),
      .start_total_i(start_bytes_i),
      .start_delay_i(start_delay_i),
      .rsp_i        (rsp_valid_i && (rsp_tag_i == TAG_W'(g))),
      .rsp_size_i   (rsp_bytes_i),
      .busy_o       (slot_busy[g]),
      .done_o       (done_o[g]),
      .ovf_o        (slot_ovf[g])
    );
  end

  dma_inflight_ctr #(.OUT_W(OUT_W)) ctr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .inc_i(chunk_queued_i),
    .dec_i(rsp_valid_i),
    .cnt_o(out_cnt),
    .unf_o(cnt_unf)
  );

  dma_drain_fsm drain_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (drain_req_i),
    .empty_i   (out_cnt == '0),
    .draining_o(draining_o),
    .done_o    (drain_done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_q | (|slot_ovf);
      unf_q <= unf_q | cnt_unf;
    end
  end

  assign err_overflow_o  = ovf_q;
  assign err_underflow_o = unf_q;
endmodule

// File: rtl/dma_done_tracker_chk.sv
module dma_done_tracker_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int OUT_W     = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 chunk_queued_i,
  input logic                 rsp_valid_i,
  input logic                 drain_req_i,
  input logic [NUM_SLOTS-1:0] done_o,
  input logic [NUM_SLOTS-1:0] slot_busy,
  input logic [OUT_W-1:0]     out_cnt,
  input logic                 draining_o,
  input logic                 drain_done_o,
  input logic                 err_overflow_o,
  input logic                 err_underflow_o
);
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_o) |-> ((done_o & ~$past(slot_busy)) == '0)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow_o |=> err_overflow_o); // R4
  AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_queued_i && !rsp_valid_i) |=> (out_cnt == OUT_W'($past(out_cnt) + 1'b1))); // R6
  AST_UNF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_i && !chunk_queued_i && (out_cnt == '0)) |=> (err_underflow_o && (out_cnt == '0))); // R7
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow_o |=> err_underflow_o); // R7
  AST_DRAIN_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req_i && !draining_o && (out_cnt == '0)) |=> drain_done_o); // R8
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done_o |-> ($past(out_cnt) == '0)); // R9
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_o) |-> ((done_o & slot_busy) == '0)); // R10
endmodule

bind dma_done_tracker dma_done_tracker_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .OUT_W    (OUT_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .chunk_queued_i (chunk_queued_i),
  .rsp_valid_i    (rsp_valid_i),
  .drain_req_i    (drain_req_i),
  .done_o         (done_o),
  .slot_busy      (slot_busy),
  .out_cnt        (out_cnt),
  .draining_o     (draining_o),
  .drain_done_o   (drain_done_o),
  .err_overflow_o (err_overflow_o),
  .err_underflow_o(err_underflow_o)
);

// File: tb/dma_done_tracker_tb_top.sv
`timescale 1ns/1ps
module dma_done_tracker_tb_top;
  localparam int NS = 4;
  localparam int BW = 12;
  localparam int DW = 4;
  localparam int OW = 8;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid_i = 1'b0;
  logic start_ready_o;
  logic [TW-1:0] start_tag_i = '0;
  logic [BW-1:0] start_bytes_i = '0;
  logic [DW-1:0] start_delay_i = '0;
  logic chunk_queued_i = 1'b0;
  logic rsp_valid_i = 1'b0;
  logic [TW-1:0] rsp_tag_i = '0;
  logic [BW-1:0] rsp_bytes_i = '0;
  logic drain_req_i = 1'b0;
  logic [NS-1:0] done_o;
  logic draining_o, drain_done_o, err_overflow_o, err_underflow_o;

  always #4 clk = ~clk;

  dma_done_tracker #(.NUM_SLOTS(NS), .BYTE_W(BW), .DLY_W(DW), .OUT_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_valid_i(start_valid_i), .start_ready_o(start_ready_o),
    .start_tag_i(start_tag_i), .start_bytes_i(start_bytes_i), .start_delay_i(start_delay_i),
    .chunk_queued_i(chunk_queued_i),
    .rsp_valid_i(rsp_valid_i), .rsp_tag_i(rsp_tag_i), .rsp_bytes_i(rsp_bytes_i),
    .drain_req_i(drain_req_i), .done_o(done_o),
    .draining_o(draining_o), .drain_done_o(drain_done_o),
    .err_overflow_o(err_overflow_o), .err_underflow_o(err_underflow_o)
  );

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int done_cnt[NS];
  int last_done[NS];
  int dd_cnt = 0;

  // behavioural reference state: 0 free, 1 collecting, 2 holding
  int m_st[NS], m_tot[NS], m_rcv[NS], m_dly[NS], m_wait[NS];
  bit m_done[NS];
  bit m_ovf, m_unf, m_drn, m_dd;
  int m_out;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_st[i] = 0; m_tot[i] = 0; m_rcv[i] = 0; m_dly[i] = 0; m_wait[i] = 0; m_done[i] = 0;
      end
      m_ovf = 0; m_unf = 0; m_drn = 0; m_dd = 0; m_out = 0;
    end else begin
      int old_out;
      old_out = m_out;
      for (int i = 0; i < NS; i++) begin
        bit hit;
        hit = rsp_valid_i && (int'(rsp_tag_i) == i);
        m_done[i] = 0;
        if (m_st[i] == 0) begin
          if (hit) m_ovf = 1;
          if (start_valid_i && int'(start_tag_i) == i) begin
            m_tot[i] = int'(start_bytes_i); m_rcv[i] = 0; m_dly[i] = int'(start_delay_i);
            if (start_bytes_i == 0) begin m_st[i] = 2; m_wait[i] = int'(start_delay_i); end
            else m_st[i] = 1;
          end
        end else if (m_st[i] == 1) begin
          if (hit) begin
            if (m_rcv[i] + int'(rsp_bytes_i) > m_tot[i]) m_ovf = 1;
            else begin
              m_rcv[i] += int'(rsp_bytes_i);
              if (m_rcv[i] == m_tot[i]) begin m_st[i] = 2; m_wait[i] = m_dly[i]; end
            end
          end
        end else begin
          if (hit) m_ovf = 1;
          if (m_wait[i] == 0) begin m_done[i] = 1; m_st[i] = 0; end
          else m_wait[i]--;
        end
      end
      if (chunk_queued_i && !rsp_valid_i) m_out = (m_out + 1) % (1 << OW);
      else if (rsp_valid_i && !chunk_queued_i) begin
        if (m_out == 0) m_unf = 1; else m_out--;
      end
      m_dd = 0;
      if (m_drn) begin
        if (old_out == 0) begin m_dd = 1; m_drn = 0; end
      end else if (drain_req_i) begin
        if (old_out == 0) m_dd = 1; else m_drn = 1;
      end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NS-1:0] ed;
      for (int i = 0; i < NS; i++) ed[i] = m_done[i];
      chk(done_o === ed, "R3", int'(done_o), int'(ed));
      chk(start_ready_o === (m_st[start_tag_i] == 0), "R1", int'(start_ready_o), int'(m_st[start_tag_i] == 0));
      chk(err_overflow_o === m_ovf, "R4", int'(err_overflow_o), int'(m_ovf));
      chk(err_underflow_o === m_unf, "R7", int'(err_underflow_o), int'(m_unf));
      chk(drain_done_o === m_dd, "R8", int'(drain_done_o), int'(m_dd));
      chk(draining_o === m_drn, "R9", int'(draining_o), int'(m_drn));
      if (done_o[start_tag_i] === 1'b1)
        chk(start_ready_o === 1'b1, "R10", int'(start_ready_o), 1);
      for (int i = 0; i < NS; i++)
        if (done_o[i] === 1'b1) begin done_cnt[i]++; last_done[i] = cyc; end
      if (drain_done_o === 1'b1) dd_cnt++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clr();
    start_valid_i = 0; chunk_queued_i = 0; rsp_valid_i = 0; drain_req_i = 0;
  endtask

  task automatic do_reset();
    clr();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NS; i++) begin done_cnt[i] = 0; last_done[i] = 0; end
    dd_cnt = 0;
    rst_n = 1;
  endtask

  task automatic open_slot(input int tag, input int tot, input int dly, output int at);
    start_valid_i = 1; start_tag_i = TW'(tag); start_bytes_i = BW'(tot); start_delay_i = DW'(dly);
    at = cyc;
    tick(); clr();
  endtask

  task automatic respond(input int tag, input int sz, input bit q, output int at);
    rsp_valid_i = 1; rsp_tag_i = TW'(tag); rsp_bytes_i = BW'(sz); chunk_queued_i = q;
    at = cyc;
    tick(); clr();
  endtask

  initial begin
    int t0, t1, ta, tb;
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk(done_o === '0 && !err_overflow_o && !err_underflow_o && !draining_o && !drain_done_o,
        "R1", int'(done_o), 0);
    chk(start_ready_o === 1'b1, "R1", int'(start_ready_o), 1);
    tick();

    // R8: drain with nothing in flight
    drain_req_i = 1; tick(); clr();
    repeat (2) tick();
    chk(dd_cnt == 1, "R8", dd_cnt, 1);

    // R2/R3/R9: two chunks, padded response credit by requested size
    open_slot(0, 100, 3, t0);
    chunk_queued_i = 1; tick(); tick(); clr();
    drain_req_i = 1; tick(); clr();
    tick();
    chk(draining_o === 1'b1, "R9", int'(draining_o), 1);
    respond(0, 64, 0, t1);
    respond(0, 36, 0, t1);
    repeat (8) tick();
    chk(done_cnt[0] == 1, "R2", done_cnt[0], 1);
    chk(last_done[0] - t1 == 3 + 2, "R3", last_done[0] - t1, 5);
    chk(dd_cnt == 2, "R9", dd_cnt, 2);

    // R5: zero-length transfer
    open_slot(1, 0, 2, t0);
    repeat (6) tick();
    chk(done_cnt[1] == 1, "R5", done_cnt[1], 1);
    chk(last_done[1] - t0 == 4, "R5", last_done[1] - t0, 4);

    // R11: overlapping waits on two slots
    open_slot(2, 8, 6, t0);
    open_slot(3, 8, 1, t0);
    chunk_queued_i = 1; tick(); tick(); clr();
    start_tag_i = 2;
    respond(2, 8, 0, ta);
    respond(3, 8, 0, tb);
    repeat (12) tick();
    chk(last_done[2] - ta == 8, "R11", last_done[2] - ta, 8);
    chk(last_done[3] - tb == 3, "R11", last_done[3] - tb, 3);
    chk(last_done[3] < last_done[2], "R11", last_done[3], last_done[2]);

    // R6: simultaneous queue and response leaves the count alone
    open_slot(0, 4, 0, t0);
    respond(0, 4, 1, t1);
    drain_req_i = 1; tick(); clr(); tick();
    chk(drain_done_o === 1'b0 && draining_o === 1'b0, "R6", int'(draining_o), 0);
    chk(dd_cnt == 3, "R6", dd_cnt, 3);

    // random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      start_valid_i  = ($urandom % 3) == 0;
      start_tag_i    = TW'($urandom);
      start_bytes_i  = (($urandom % 4) == 0) ? '0 : BW'($urandom_range(1, 40));
      start_delay_i  = DW'($urandom);
      chunk_queued_i = ($urandom % 10) < 3;
      rsp_valid_i    = ($urandom % 10) < 3;
      rsp_tag_i      = TW'($urandom);
      rsp_bytes_i    = BW'($urandom_range(1, 12));
      drain_req_i    = ($urandom % 20) == 0;
      tick();
    end
    clr();
    repeat (20) tick();

    // R4: overshoot leaves the sum untouched
    do_reset();
    open_slot(0, 10, 0, t0);
    chunk_queued_i = 1; tick(); tick(); clr();
    respond(0, 16, 0, t1);
    tick();
    chk(err_overflow_o === 1'b1, "R4", int'(err_overflow_o), 1);
    respond(0, 10, 0, t1);
    repeat (3) tick();
    chk(done_cnt[0] == 1, "R4", done_cnt[0], 1);

    // R7: response with nothing in flight
    chk(err_underflow_o === 1'b0, "R7", int'(err_underflow_o), 0);
    respond(1, 4, 0, t1);
    tick();
    chk(err_underflow_o === 1'b1, "R7", int'(err_underflow_o), 1);
    drain_req_i = 1; tick(); clr(); tick();
    chk(dd_cnt == 1, "R7", dd_cnt, 1);

    repeat (4) tick();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule